// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Comparator

This block watches every qualified cycle on a processor bus and compares it against two programmable breakpoint channels, A and B. Each channel checks the bus address against its own address value under a mask. It also checks the cycle's kind (instruction fetch or data access), its direction, its operand size and the bus it ran on. Channel B can additionally require the bus data to equal a programmed value under a data mask.

A control bit picks between two modes. In independent mode either channel raises a break on its own. In sequential mode a channel A hit only arms the block, and a break is raised by a later channel B hit. The break request is a single-cycle pulse in the cycle after the matching bus cycle, so an instruction-fetch break reaches the core before the fetched instruction executes. Two sticky match flags record which channel hit, and software clears them with a register write.

Top module: `dual_brk_unit`

## Requirements
- R1: After reset `brk_req`, `match_a` and `match_b` are 0 and every register is zero. A condition field of zero disables its channel, so no bus cycle can match.
- R2: Registers are written when `wr_en` is high, at the rising edge, by offset: 0 A address, 1 A mask, 2 A condition, 3 B address, 4 B mask, 5 B condition, 6 B data, 7 B data mask, 8 control, 9 flag clear. An address bit takes part in the compare when its mask bit is 0 and is ignored when its mask bit is 1.
- R3: Condition field bits are [1:0] kind (bit0 allows fetch, bit1 allows data), [3:2] direction (bit2 allows read, bit3 allows write), [5:4] size (0 any, 1 byte, 2 word, 3 long, compared with `bus_size`) and [7:6] bus (0 or 3 either, 1 requires `bus_id`=0, 2 requires `bus_id`=1). Every selected part must agree with the bus cycle.
- R4: A fetch cycle counts as a read whatever `bus_write` shows. A channel that allows only fetch and only write never matches.
- R5: A fetch cycle at an odd address (`bus_addr[0]`=1) never matches either channel.
- R6: With channel B condition bit 8 set, a channel B match also needs `bus_data` to equal the B data register on every bit whose data mask bit is 0.
- R7: When control bit 3 is 0 (independent mode), a match on either channel pulses `brk_req` high for exactly the cycle after the bus cycle.
- R8: When control bit 3 is 1 (sequential mode), a channel A match raises no break and sets an armed state. A later channel B match raises the break. Raising the break or writing the control register clears the armed state, and a channel B match without it gives no break.
- R9: `match_a` and `match_b` go high in the cycle after their channel matches and stay high until a write to offset 9 with data bit 0 (A) or bit 1 (B) set. A new match in the same cycle wins over the clear.
- R10: A cycle with `bus_valid` low matches nothing and changes neither the flags nor the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 32 | Register write data |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data |
| bus_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| bus_write | input | 1 | 1 for write direction |
| bus_size | input | 2 | Operand size: 1 byte, 2 word, 3 long |
| bus_id | input | 1 | Which bus carries the cycle |
| brk_req | output | 1 | One-cycle break request pulse |
| match_a | output | 1 | Sticky channel A match flag |
| match_b | output | 1 | Sticky channel B match flag |

## Verification
The hardest case to reach is the armed state in sequential mode, because it is never visible at the ports. The stimulus arms it with a channel A hit and probes it with channel B cycles. It first confirms that B alone gives nothing, then that A followed by B breaks once and a second B does not. Last, it shows that a control write between A and B disarms the block. The fetch corner cases are also driven directly: a write direction shown on a fetch, and a fetch at an odd address that otherwise matches.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned COND_W = 9;

  localparam logic [REG_AW-1:0] OFS_A_ADDR  = 4'd0;
  localparam logic [REG_AW-1:0] OFS_A_MASK  = 4'd1;
  localparam logic [REG_AW-1:0] OFS_A_COND  = 4'd2;
  localparam logic [REG_AW-1:0] OFS_B_ADDR  = 4'd3;
  localparam logic [REG_AW-1:0] OFS_B_MASK  = 4'd4;
  localparam logic [REG_AW-1:0] OFS_B_COND  = 4'd5;
  localparam logic [REG_AW-1:0] OFS_B_DATA  = 4'd6;
  localparam logic [REG_AW-1:0] OFS_B_DMASK = 4'd7;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 4'd8;
  localparam logic [REG_AW-1:0] OFS_CLR     = 4'd9;

  localparam int unsigned SEQ_BIT = 3;
  localparam int unsigned NCH     = 2;

  typedef struct packed {
    logic       dcmp;
    logic [1:0] bsel;
    logic [1:0] size;
    logic [1:0] dir;
    logic [1:0] kind;
  } cond_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  output logic [NCH-1:0][AW-1:0] ch_addr,
  output logic [NCH-1:0][AW-1:0] ch_mask,
  output logic [NCH-1:0][COND_W-1:0] ch_cond,
  output logic [DW-1:0]          b_data,
  output logic [DW-1:0]          b_dmask,
  output logic                   seq_mode,
  output logic                   ctrl_wr,
  output logic                   clr_a,
  output logic                   clr_b
);
  logic [NCH-1:0][AW-1:0]     addr_q, addr_d;
  logic [NCH-1:0][AW-1:0]     mask_q, mask_d;
  logic [NCH-1:0][COND_W-1:0] cond_q, cond_d;
  logic [DW-1:0]              data_q, data_d, dmask_q, dmask_d;
  logic                       seq_q, seq_d;

  always_comb begin
    addr_d  = addr_q;
    mask_d  = mask_q;
    cond_d  = cond_q;
    data_d  = data_q;
    dmask_d = dmask_q;
    seq_d   = seq_q;
    if (wr_en) begin
      unique case (wr_addr)
        OFS_A_ADDR:  addr_d[0] = wr_data[AW-1:0];
        OFS_A_MASK:  mask_d[0] = wr_data[AW-1:0];
        OFS_A_COND:  cond_d[0] = wr_data[COND_W-1:0];
        OFS_B_ADDR:  addr_d[1] = wr_data[AW-1:0];
        OFS_B_MASK:  mask_d[1] = wr_data[AW-1:0];
        OFS_B_COND:  cond_d[1] = wr_data[COND_W-1:0];
        OFS_B_DATA:  data_d    = wr_data[DW-1:0];
        OFS_B_DMASK: dmask_d   = wr_data[DW-1:0];
        OFS_CTRL:    seq_d     = wr_data[SEQ_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      mask_q  <= '0;
      cond_q  <= '0;
      data_q  <= '0;
      dmask_q <= '0;
      seq_q   <= 1'b0;
    end else if (wr_en) begin
      addr_q  <= addr_d;
      mask_q  <= mask_d;
      cond_q  <= cond_d;
      data_q  <= data_d;
      dmask_q <= dmask_d;
      seq_q   <= seq_d;
    end
  end

  assign ch_addr  = addr_q;
  assign ch_mask  = mask_q;
  assign ch_cond  = cond_q;
  assign b_data   = data_q;
  assign b_dmask  = dmask_q;
  assign seq_mode = seq_q;
  assign ctrl_wr  = wr_en && (wr_addr == OFS_CTRL);
  assign clr_a    = wr_en && (wr_addr == OFS_CLR) && wr_data[0];
  assign clr_b    = wr_en && (wr_addr == OFS_CLR) && wr_data[1];
endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter bit          HAS_DATA = 1'b0
) (
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic              bus_id,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [AW-1:0]     cfg_mask,
  input  logic [COND_W-1:0] cfg_cond,
  input  logic [DW-1:0]     cfg_data,
  input  logic [DW-1:0]     cfg_dmask,
  output logic              hit
);
  cond_t c;
  logic  eff_write, kind_ok, dir_ok, size_ok, bus_ok, align_ok, addr_ok, data_ok;

  assign c = cond_t'(cfg_cond);

  always_comb begin
    eff_write = bus_write && !bus_fetch;
    kind_ok   = bus_fetch ? c.kind[0] : c.kind[1];
    dir_ok    = eff_write ? c.dir[1]  : c.dir[0];
    size_ok   = (c.size == 2'd0) || (c.size == bus_size);
    unique case (c.bsel)
      2'd1:    bus_ok = !bus_id;
      2'd2:    bus_ok = bus_id;
      default: bus_ok = 1'b1;
    endcase
    align_ok  = !(bus_fetch && bus_addr[0]);
    addr_ok   = ((bus_addr ^ cfg_addr) & ~cfg_mask) == '0;
  end

  generate
    if (HAS_DATA) begin : g_dcmp
      assign data_ok = !c.dcmp || (((bus_data ^ cfg_data) & ~cfg_dmask) == '0);
    end else begin : g_nodcmp
      logic unused_ok;
      assign unused_ok = c.dcmp ^ (^bus_data) ^ (^cfg_data) ^ (^cfg_dmask);
      assign data_ok   = unused_ok | 1'b1;
    end
  endgenerate

  assign hit = bus_valid && kind_ok && dir_ok && size_ok && bus_ok &&
               align_ok && addr_ok && data_ok;
endmodule

// File: rtl/brk_seq.sv
module brk_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_a,
  input  logic hit_b,
  input  logic seq_mode,
  input  logic ctrl_wr,
  input  logic clr_a,
  input  logic clr_b,
  output logic brk_req,
  output logic match_a,
  output logic match_b,
  output logic armed
);
  logic fire, brk_q, fa_q, fb_q, arm_q;
  logic brk_d, fa_d, fb_d, arm_d;

  always_comb begin
    fire  = seq_mode ? (hit_b && arm_q) : (hit_a || hit_b);
    brk_d = fire;
    fa_d  = hit_a || (fa_q && !clr_a);
    fb_d  = hit_b || (fb_q && !clr_b);
    if (!seq_mode || ctrl_wr || fire) arm_d = 1'b0;
    else if (hit_a)                    arm_d = 1'b1;
    else                               arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      fa_q  <= 1'b0;
      fb_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      brk_q <= brk_d;
      fa_q  <= fa_d;
      fb_q  <= fb_d;
      arm_q <= arm_d;
    end
  end

  assign brk_req = brk_q;
  assign match_a = fa_q;
  assign match_b = fb_q;
  assign armed   = arm_q;
endmodule

// File: rtl/dual_brk_unit.sv
module dual_brk_unit
  import brk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic              bus_id,
  output logic              brk_req,
  output logic              match_a,
  output logic              match_b
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NCH-1:0][AW-1:0]     ch_addr, ch_mask;
  logic [NCH-1:0][COND_W-1:0] ch_cond;
  logic [DW-1:0]              b_data, b_dmask;
  logic                       seq_mode, ctrl_wr, clr_a, clr_b, armed;
  logic [NCH-1:0]             hit;

  brk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_addr(ch_addr), .ch_mask(ch_mask),
    .ch_cond(ch_cond), .b_data(b_data), .b_dmask(b_dmask),
    .seq_mode(seq_mode), .ctrl_wr(ctrl_wr), .clr_a(clr_a), .clr_b(clr_b)
  );

  for (genvar ci = 0; ci < NCH; ci++) begin : g_ch
    brk_chan #(.AW(AW), .DW(DW), .HAS_DATA(ci == 1)) u_chan (
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
      .bus_id(bus_id), .cfg_addr(ch_addr[ci]), .cfg_mask(ch_mask[ci]),
      .cfg_cond(ch_cond[ci]), .cfg_data(b_data), .cfg_dmask(b_dmask),
      .hit(hit[ci])
    );
  end

  brk_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .hit_a(hit[0]), .hit_b(hit[1]),
    .seq_mode(seq_mode), .ctrl_wr(ctrl_wr), .clr_a(clr_a), .clr_b(clr_b),
    .brk_req(brk_req), .match_a(match_a), .match_b(match_b), .armed(armed)
  );
endmodule

// File: rtl/dual_brk_chk.sv
module dual_brk_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [1:0] wr_lo,
  input logic       bus_valid,
  input logic       brk_req,
  input logic       match_a,
  input logic       match_b,
  input logic       seq_mode,
  input logic       armed
);
  // R7
  brk_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_req |-> $past(bus_valid));
  // R7
  brk_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_req |-> (match_a || match_b));
  // R8
  seq_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_req && $past(seq_mode)) |-> $past(armed));
  // R9
  flag_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (match_a && !(wr_en && wr_addr == 4'd9 && wr_lo[0])) |=> match_a);
  // R9
  flag_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (match_b && !(wr_en && wr_addr == 4'd9 && wr_lo[1])) |=> match_b);
  // R10
  flag_rise_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(match_a) || $rose(match_b) || $rose(armed)) |-> $past(bus_valid));
endmodule

bind dual_brk_unit dual_brk_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_lo(wr_data[1:0]), .bus_valid(bus_valid), .brk_req(brk_req),
  .match_a(match_a), .match_b(match_b), .seq_mode(seq_mode), .armed(armed)
);

// File: tb/sim_dual_brk_unit.sv
module sim_dual_brk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic        bus_fetch = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic        bus_id = 1'b0;
  logic        brk_req, match_a, match_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dual_brk_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_size(bus_size), .bus_id(bus_id), .brk_req(brk_req),
    .match_a(match_a), .match_b(match_b)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {brk,a,b} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one bus cycle; after it returns the outputs show that cycle's result
  task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic f,
                     input logic w, input logic [1:0] sz, input logic id,
                     input logic v = 1'b1);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_data = d; bus_fetch = f;
    bus_write = w; bus_size = sz; bus_id = id;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic clean();
    for (int r = 0; r < 9; r++) wr(r[3:0], 32'd0);
    wr(4'd9, 32'd3);
  endtask

  task automatic t_reset();
    chk("R1 reset", {brk_req, match_a, match_b}, 3'b000);
    cyc(32'd0, 32'd0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R1 zero cond disabled", {brk_req, match_a, match_b}, 3'b000);
    cyc(32'd0, 32'd0, 1'b1, 1'b0, 2'd2, 1'b0);
    chk("R1 zero cond fetch", {brk_req, match_a, match_b}, 3'b000);
  endtask

  task automatic t_addr();
    clean();
    wr(4'd0, 32'h1000); wr(4'd2, 32'h006);
    cyc(32'h1000, 0, 1'b0, 1'b0, 2'd3, 1'b0);
    chk("R2 R7 exact addr", {brk_req, match_a, match_b}, 3'b110);
    @(negedge clk);
    chk("R7 single pulse", {brk_req, match_a, match_b}, 3'b010);
    cyc(32'h1004, 0, 1'b0, 1'b0, 2'd3, 1'b0);
    chk("R2 addr differs", {brk_req, match_a, match_b}, 3'b010);
    wr(4'd1, 32'h0000000F);
    cyc(32'h100C, 0, 1'b0, 1'b0, 2'd3, 1'b0);
    chk("R2 masked bits", {brk_req, match_a, match_b}, 3'b110);
    cyc(32'h1010, 0, 1'b0, 1'b0, 2'd3, 1'b0);
    chk("R2 unmasked bit differs", {brk_req, match_a, match_b}, 3'b010);
  endtask

  task automatic t_cond();
    clean();
    wr(4'd0, 32'h1000); wr(4'd2, 32'h026);
    cyc(32'h1000, 0, 1'b0, 1'b0, 2'd3, 1'b0);
    chk("R3 size long vs word", {brk_req, match_a, match_b}, 3'b000);
    cyc(32'h1000, 0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R3 size word", {brk_req, match_a, match_b}, 3'b110);
    cyc(32'h1000, 0, 1'b0, 1'b1, 2'd2, 1'b0);
    chk("R3 write vs read", {brk_req, match_a, match_b}, 3'b010);
    cyc(32'h1000, 0, 1'b1, 1'b0, 2'd2, 1'b0);
    chk("R3 fetch vs data", {brk_req, match_a, match_b}, 3'b010);
    wr(4'd2, 32'h046);
    cyc(32'h1000, 0, 1'b0, 1'b0, 2'd1, 1'b1);
    chk("R3 wrong bus", {brk_req, match_a, match_b}, 3'b010);
    cyc(32'h1000, 0, 1'b0, 1'b0, 2'd1, 1'b0);
    chk("R3 right bus", {brk_req, match_a, match_b}, 3'b110);
  endtask

  task automatic t_fetch();
    clean();
    wr(4'd0, 32'h2000); wr(4'd2, 32'h009);
    cyc(32'h2000, 0, 1'b1, 1'b1, 2'd2, 1'b0);
    chk("R4 fetch with write never", {brk_req, match_a, match_b}, 3'b000);
    wr(4'd0, 32'h2001); wr(4'd2, 32'h005);
    cyc(32'h2001, 0, 1'b1, 1'b0, 2'd2, 1'b0);
    chk("R5 odd fetch never", {brk_req, match_a, match_b}, 3'b000);
    wr(4'd0, 32'h2000);
    cyc(32'h2000, 0, 1'b1, 1'b1, 2'd2, 1'b0);
    chk("R4 fetch reads as read", {brk_req, match_a, match_b}, 3'b110);
  endtask

  task automatic t_data();
    clean();
    wr(4'd3, 32'h3000); wr(4'd5, 32'h106); wr(4'd6, 32'h55AA);
    cyc(32'h3000, 32'h55AA, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R6 data equal", {brk_req, match_a, match_b}, 3'b101);
    wr(4'd9, 32'd2);
    cyc(32'h3000, 32'h55AB, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R6 data differs", {brk_req, match_a, match_b}, 3'b000);
    wr(4'd7, 32'hFF);
    cyc(32'h3000, 32'h5512, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R6 data masked", {brk_req, match_a, match_b}, 3'b101);
  endtask

  task automatic t_seq();
    clean();
    wr(4'd0, 32'h4000); wr(4'd2, 32'h005);
    wr(4'd3, 32'h5000); wr(4'd5, 32'h006);
    wr(4'd8, 32'h8);
    cyc(32'h5000, 0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R8 B alone", {brk_req, match_a, match_b}, 3'b001);
    wr(4'd9, 32'd3);
    cyc(32'h4000, 0, 1'b1, 1'b0, 2'd2, 1'b0);
    chk("R8 A alone no break", {brk_req, match_a, match_b}, 3'b010);
    cyc(32'h5000, 0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R8 A then B", {brk_req, match_a, match_b}, 3'b111);
    cyc(32'h5000, 0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R8 disarmed after break", {brk_req, match_a, match_b}, 3'b011);
    cyc(32'h4000, 0, 1'b1, 1'b0, 2'd2, 1'b0);
    wr(4'd8, 32'h8);
    cyc(32'h5000, 0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R8 ctrl write disarms", {brk_req, match_a, match_b}, 3'b011);
    wr(4'd8, 32'h0);
    cyc(32'h5000, 0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R7 B alone independent", {brk_req, match_a, match_b}, 3'b111);
  endtask

  task automatic t_flags();
    wr(4'd9, 32'd1);
    chk("R9 clear A only", {brk_req, match_a, match_b}, 3'b001);
    wr(4'd9, 32'd2);
    chk("R9 clear B", {brk_req, match_a, match_b}, 3'b000);
  endtask

  task automatic t_valid();
    clean();
    wr(4'd0, 32'h6000); wr(4'd2, 32'h006);
    cyc(32'h6000, 0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0);
    chk("R10 invalid ignored", {brk_req, match_a, match_b}, 3'b000);
    wr(4'd8, 32'h8); wr(4'd3, 32'h7000); wr(4'd5, 32'h006);
    cyc(32'h6000, 0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0);
    cyc(32'h7000, 0, 1'b0, 1'b0, 2'd2, 1'b0);
    chk("R10 invalid A does not arm", {brk_req, match_a, match_b}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr();
    t_cond();
    t_fetch();
    t_data();
    t_seq();
    t_flags();
    t_valid();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule